// File: doc/BRIEF.md
# Bottom-up 4bpp bitmap pixel unpacker

This block reads a raw bitmap with four bits per pixel straight out of a byte-wide synchronous memory and turns it into a stream of digital colour pixels (intensity, red, green, blue) for a 640 by 200 display. A separate timing generator supplies one pixel request strobe per pixel slot. With each strobe it also supplies the active-region column and line and a data-enable flag. The block works out which byte holds the pixel, issues the read, and splits the returned byte into two pixels.

The stored image starts with a fixed 118-byte header. Its rows are stored bottom-up with no padding. Each byte carries two pixels: the high nibble is the left pixel and the low nibble is the right one. The block handles this layout in hardware, so the file can be placed in memory unchanged. Outside the active region the colour lines show a dark-blue border rather than black.

Each pixel leaves the block three clocks after its request. The data-enable output is delayed by the same three clocks, so it stays aligned with the colour lines.

Top module: `bmp4_scan_unpack`

## Requirements
- R1: During and right after a synchronous active-low reset, mem_rd and de_out are 0 and the colour lines show the border colour {inten,red,grn,blu} = 4'b0001.
- R2: A memory read (mem_rd = 1) is issued exactly one clock after a request with de_in = 1 and an even x_in. Requests with odd x_in or with de_in = 0 issue no read.
- R3: The read address is 118 + (199 - y)*320 + x/2, using integer division. Line 0 therefore reads the last stored row.
- R4: The memory returns data one clock after the address. An even-column pixel takes the high nibble (bits 7:4) of its byte. The following odd-column pixel takes the low nibble (bits 3:0) of the same byte, which the block holds in a register.
- R5: The pixel code maps to the colour lines as follows: bit 3 drives inten, bit 2 drives red, bit 1 drives green and bit 0 drives blue.
- R6: A request with de_in = 0 produces the border colour 4'b0001 (inten, red and green low, blue high) and de_out = 0.
- R7: The colour lines and de_out for a request change on the third rising clock edge after that request is sampled.
- R8: A clock with px_req = 0 leaves de_out and the colour lines unchanged three clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| px_req | input | 1 | Pixel request strobe from the timing generator |
| de_in | input | 1 | Active-region flag for this request |
| x_in | input | 10 | Active-region column, 0 to 639 |
| y_in | input | 8 | Active-region line, 0 to 199 |
| mem_rd | output | 1 | Read strobe to the byte memory |
| mem_addr | output | 17 | Byte address of the read |
| mem_data | input | 8 | Read data, valid one clock after the address |
| de_out | output | 1 | Data enable aligned with the colour lines |
| inten | output | 1 | Intensity line |
| red | output | 1 | Red line |
| grn | output | 1 | Green line |
| blu | output | 1 | Blue line |

## Verification
With back-to-back requests, two things happen in the same clock. The odd pixel of one byte is emitted from the held register, and the read for the next byte is in flight, so the memory data bus is about to change. A sweep of the whole frame with no gaps makes this happen on every byte pair. Every emitted pixel is compared with the nibble expected at the flipped-row address. A random phase then puts idle gaps between the two halves of a pair and mixes in border requests. A correct design must show that the held byte, not the live bus, feeds the odd pixel.

// File: rtl/bmp4_scan_unpack.sv
module bmp4_scan_unpack #(
  parameter int ACT_W     = 640,
  parameter int ACT_H     = 200,
  parameter int HDR_BYTES = 118,
  parameter int AW        = 17,
  parameter int XW        = 10,
  parameter int YW        = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          px_req,
  input  logic          de_in,
  input  logic [XW-1:0] x_in,
  input  logic [YW-1:0] y_in,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_data,
  output logic          de_out,
  output logic          inten,
  output logic          red,
  output logic          grn,
  output logic          blu
);
  localparam int ROW_BYTES = ACT_W / 2;
  localparam logic [3:0] BORDER = 4'b0001;

  logic [AW-1:0] row_flip, byte_addr;
  logic          fetch;

  assign row_flip  = AW'(ACT_H - 1) - AW'(y_in);
  assign byte_addr = AW'(HDR_BYTES) + row_flip * AW'(ROW_BYTES) + AW'(x_in >> 1);
  assign fetch     = px_req & de_in & ~x_in[0];

  logic       s1_req, s1_de, s1_odd;
  logic       s2_req, s2_de, s2_odd;
  logic [7:0] byte_q;
  logic [3:0] pix_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_req   <= 1'b0;
      s1_de    <= 1'b0;
      s1_odd   <= 1'b0;
      s2_req   <= 1'b0;
      s2_de    <= 1'b0;
      s2_odd   <= 1'b0;
      mem_rd   <= 1'b0;
      mem_addr <= '0;
      byte_q   <= '0;
      pix_q    <= BORDER;
      de_out   <= 1'b0;
    end else begin
      s1_req <= px_req;
      s1_de  <= de_in;
      s1_odd <= x_in[0];
      mem_rd <= fetch;
      if (fetch) mem_addr <= byte_addr;
      s2_req <= s1_req;
      s2_de  <= s1_de;
      s2_odd <= s1_odd;
      if (s2_req) begin
        de_out <= s2_de;
        if (!s2_de) begin
          pix_q <= BORDER;
        end else if (s2_odd) begin
          pix_q <= byte_q[3:0];
        end else begin
          pix_q  <= mem_data[7:4];
          byte_q <= mem_data;
        end
      end
    end
  end

  assign {inten, red, grn, blu} = pix_q;
endmodule

module bmp4_scan_unpack_chk #(
  parameter int ACT_W     = 640,
  parameter int ACT_H     = 200,
  parameter int HDR_BYTES = 118,
  parameter int AW        = 17,
  parameter int XW        = 10,
  parameter int YW        = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          px_req,
  input logic          de_in,
  input logic [XW-1:0] x_in,
  input logic [YW-1:0] y_in,
  input logic          mem_rd,
  input logic [AW-1:0] mem_addr,
  input logic [7:0]    mem_data,
  input logic          de_out,
  input logic          inten,
  input logic          red,
  input logic          grn,
  input logic          blu
);
  localparam int ROW_BYTES = ACT_W / 2;
  localparam logic [AW-1:0] LO_ADDR  = AW'(HDR_BYTES);
  localparam logic [AW-1:0] HI_ADDR  = AW'(HDR_BYTES + ROW_BYTES * ACT_H);
  localparam logic [AW-1:0] BOT_BASE = AW'(HDR_BYTES + ROW_BYTES * (ACT_H - 1));

  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  AST_RD_ONLY_EVEN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0 && mem_rd) |-> ($past(px_req) && $past(de_in) && !$past(x_in[0]))); // R2

  AST_ADDR_IN_IMAGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (mem_addr >= LO_ADDR && mem_addr < HI_ADDR)); // R3

  AST_TOP_LINE_READS_LAST_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0 && mem_rd && $past(y_in) == '0) |-> (mem_addr >= BOT_BASE)); // R3

  AST_BORDER_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !de_out |-> ({inten, red, grn, blu} == 4'b0001)); // R6

  AST_EVEN_HIGH_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && $past(px_req, 3) && $past(de_in, 3) && !$past(x_in[0], 3))
      |-> ({inten, red, grn, blu} == $past(mem_data[7:4]))); // R4

  AST_DE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && $past(px_req, 3)) |-> (de_out == $past(de_in, 3))); // R7

  AST_HOLD_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && !$past(px_req, 3)) |-> ($stable(de_out) && $stable({inten, red, grn, blu}))); // R8
endmodule

bind bmp4_scan_unpack bmp4_scan_unpack_chk #(
  .ACT_W(ACT_W), .ACT_H(ACT_H), .HDR_BYTES(HDR_BYTES), .AW(AW), .XW(XW), .YW(YW)
) u_chk (.*);

// File: tb/bmp4_scan_unpack_test.sv
module bmp4_scan_unpack_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        px_req = 1'b0;
  logic        de_in = 1'b0;
  logic [9:0]  x_in = '0;
  logic [7:0]  y_in = '0;
  logic        mem_rd;
  logic [16:0] mem_addr;
  logic [7:0]  mem_data = '0;
  logic        de_out, inten, red, grn, blu;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bmp4_scan_unpack uut (
    .clk(clk), .rst_n(rst_n), .px_req(px_req), .de_in(de_in),
    .x_in(x_in), .y_in(y_in), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_data(mem_data), .de_out(de_out), .inten(inten), .red(red),
    .grn(grn), .blu(blu)
  );

  function automatic logic [7:0] mem_byte(int a);
    return 8'((a * 29) ^ (a >> 7) ^ 8'h5A);
  endfunction

  function automatic int pix_addr(int x, int y);
    return 118 + (199 - y) * 320 + x / 2;
  endfunction

  function automatic logic [3:0] pix_code(int x, int y);
    logic [7:0] b;
    b = mem_byte(pix_addr(x, y));
    return (x % 2 == 0) ? b[7:4] : b[3:0];
  endfunction

  always @(posedge clk) if (mem_rd) mem_data <= mem_byte(int'(mem_addr));

  // expectation pipeline: colour stage (3 deep) and memory stage (1 deep)
  bit         c_v[1:3];
  bit         c_de[1:3];
  logic [3:0] c_col[1:3];
  bit         m_rd;
  int         m_addr;
  bit         last_de = 0;
  logic [3:0] last_col = 4'b0001;

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(bit req, bit de, int x, int y);
    @(negedge clk);
    if (c_v[3]) begin
      last_de  = c_de[3];
      last_col = c_col[3];
      if (!c_de[3]) check({inten, red, grn, blu} == 4'b0001, "R6", "border colour", {inten, red, grn, blu}, 4'b0001);
      else          check({inten, red, grn, blu} == last_col, "R4_R5", "pixel colour", {inten, red, grn, blu}, last_col);
      check(de_out == last_de, "R7", "de_out", de_out, last_de);
    end else begin
      check(de_out == last_de && {inten, red, grn, blu} == last_col, "R8", "hold on idle",
            {de_out, inten, red, grn, blu}, {last_de, last_col});
    end
    check(mem_rd == m_rd, "R2", "read strobe", mem_rd, m_rd);
    if (m_rd) check(int'(mem_addr) == m_addr, "R3", "read address", mem_addr, m_addr);
    c_v[3] = c_v[2]; c_de[3] = c_de[2]; c_col[3] = c_col[2];
    c_v[2] = c_v[1]; c_de[2] = c_de[1]; c_col[2] = c_col[1];
    c_v[1] = req; c_de[1] = de; c_col[1] = de ? pix_code(x, y) : 4'b0001;
    m_rd = req && de && (x % 2 == 0);
    m_addr = pix_addr(x, y);
    px_req = req; de_in = de; x_in = 10'(x); y_in = 8'(y);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog run did not finish actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 7;
    void'($urandom(seed));
    for (int i = 1; i <= 3; i++) begin c_v[i] = 0; c_de[i] = 0; c_col[i] = 4'b0001; end
    m_rd = 0; m_addr = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state seen at the ports
    @(negedge clk);
    check(!mem_rd && !de_out && {inten, red, grn, blu} == 4'b0001, "R1", "reset state",
          {mem_rd, de_out, inten, red, grn, blu}, 6'b000001);
    // full frame, back-to-back pixels, border slots between lines
    for (int y = 0; y < 200; y++) begin
      for (int x = 0; x < 640; x++) step(1, 1, x, y);
      for (int k = 0; k < 16; k++) step(1, 0, 0, 0);
    end
    // directed corners: first and last byte of the image
    step(1, 1, 0, 199); step(1, 1, 1, 199);
    step(1, 1, 638, 0); step(1, 1, 639, 0);
    step(0, 0, 0, 0);
    // random pairs with idle gaps and border requests
    for (int n = 0; n < 800; n++) begin
      int xp, yp, g;
      bit de;
      xp = 2 * int'($urandom_range(0, 319));
      yp = int'($urandom_range(0, 199));
      de = ($urandom_range(0, 3) != 0);
      step(1, de, xp, yp);
      g = int'($urandom_range(0, 2));
      for (int k = 0; k < g; k++) step(0, int'($urandom_range(0, 1)), int'($urandom_range(0, 639)), yp);
      step(1, de, xp + 1, yp);
      g = int'($urandom_range(0, 1));
      for (int k = 0; k < g; k++) step(0, 0, 0, 0);
    end
    for (int k = 0; k < 4; k++) step(0, 0, 0, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule